// File: doc/BRIEF.md
# Serial ADC Output Frame Emulator

This block is a synthesizable stand-in for the digital side of a serial analog-to-digital converter whose frames are framed by an active-low chip select. It serves as a peripheral model for the host's serial port. The sample value is taken from a register port. When chip select goes low, the block captures that value together with a resolution select. On the falling edges of the serial clock it then shifts out a 16-slot word. The word holds a zero prefix, the data most significant bit first, and a zero tail whose length depends on the resolution. After the sixteenth falling edge the output is released.

The block follows the conversion and acquisition phases of each frame. When chip select rises early, the frame is aborted. A rise that falls inside a fixed window of edge counts puts the block into a low-power state. To leave that state, the host sends a dummy frame that runs past ten falling edges, and the block then waits out a programmable wake-up time counted on the system clock. Every frame that cannot deliver a valid conversion shifts out zeros and reports a cleared valid flag. All pins are sampled by a two-stage synchronizer on the system clock.

Top module: `adc_frame_emu`

## Requirements
- R1: A falling edge of cs_n captures sample_in and the resolution select, restarts the falling-edge count at zero, and drives sdo_oe high with sdo low (the first prefix zero), all within three clk cycles of the pin change.
- R2: With res_8bit low, sdo after the k-th SCLK falling edge (k = 1..15) is slot k of the word {4 zeros, sample_in[9:0] MSB first, 2 zeros}: zero for k = 1..3, sample_in[13-k] for k = 4..13, and zero for k = 14..15.
- R3: With res_8bit high, the word is {4 zeros, sample_in[7:0] MSB first, 4 zeros}: sdo is sample_in[11-k] for k = 4..11 and zero for k = 1..3 and k = 12..15.
- R4: On the 16th SCLK falling edge sdo_oe goes low. The edge count saturates at 16, and further SCLK edges leave sdo_oe low.
- R5: converting rises with the chip-select fall of a frame that starts powered up. It falls on SCLK falling edge 14 (10-bit) or 12 (8-bit).
- R6: acquiring is cleared by every chip-select fall. It rises on the first SCLK rising edge after falling edge 13 (10-bit) or 11 (8-bit) of a frame that started powered up.
- R7: A rise of cs_n aborts the frame. sdo_oe and converting go low at once.
- R8: A rise of cs_n in a powered-up frame, after at least 2 and fewer than 10 SCLK falling edges, sets powered_down.
- R9: A frame that starts while powered_down is high shifts out only zeros, reports data_valid low, and leaves converting low.
- R10: In a frame that starts while powered_down is high, the 11th SCLK falling edge starts a wake-up of WAKE_CYCLES clk cycles. After it, powered_down is low, acquiring is high and the next frame is valid. A frame with 10 or fewer edges leaves the block powered down.
- R11: data_valid is updated only by a chip-select fall, and it equals "powered up and acquiring was high". A frame aborted before its acquisition point therefore makes the next frame invalid and all zeros.
- R12: sdo is low whenever sdo_oe is low. After reset, sdo_oe, converting, powered_down and data_valid are low and acquiring is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idle high |
| sample_in | input | SMP_W | Value to convert, captured on a chip-select fall |
| res_8bit | input | 1 | 1 selects 8-bit frames, 0 selects 10-bit frames |
| sdo | output | 1 | Serial data, low while released |
| sdo_oe | output | 1 | High while sdo is driven (three-state enable) |
| converting | output | 1 | Conversion in progress |
| acquiring | output | 1 | Input is tracking for the next conversion |
| powered_down | output | 1 | Low-power state, including the wake-up interval |
| data_valid | output | 1 | The current frame carries a real conversion |

## Verification
The assertions take for granted that sclk rests high when cs_n falls or rises, that cs_n and sclk never change in the same system-clock cycle, and that every pin level is held for longer than the synchronizer latency. They also assume that res_8bit and sample_in are stable around a chip-select fall. The stimulus holds every pin level for four clk cycles and changes cs_n only with sclk high. It changes sample_in and res_8bit only while cs_n is high. Random frames draw an edge count from 1 to 18, so aborts, power-down entries, dummy wake frames and runs beyond the sixteenth edge all occur.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  // Resolution captured at the start of a frame
  typedef enum logic {
    RES_WIDE   = 1'b0,
    RES_NARROW = 1'b1
  } res_e;

  // Synchronized pin edge pulses
  typedef struct packed {
    logic fall;
    logic rise;
  } pin_edge_t;

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pin_i,
  output logic                  level_o,
  output adc_emu_pkg::pin_edge_t edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      last_q <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level_o     = sync_q[STAGES-1];
  assign edge_o.rise = sync_q[STAGES-1] & ~last_q;
  assign edge_o.fall = ~sync_q[STAGES-1] & last_q;

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int FRAME_LEN = 16,
  parameter int SMP_W     = 10,
  parameter int NARROW_W  = 8,
  parameter int LEAD_Z    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             narrow_i,
  input  logic             zero_fill_i,
  input  logic [SMP_W-1:0] word_i,
  input  logic             shift_i,
  input  logic             release_i,
  output logic             sdo_o,
  output logic             oe_o
);

  localparam int TAIL_WIDE   = FRAME_LEN - LEAD_Z - SMP_W;
  localparam int TAIL_NARROW = FRAME_LEN - LEAD_Z - NARROW_W;

  logic [FRAME_LEN-1:0] shreg_q, shreg_d;
  logic [FRAME_LEN-1:0] word_wide, word_narrow;
  logic                 oe_q, oe_d;

  assign word_wide   = {{LEAD_Z{1'b0}}, word_i, {TAIL_WIDE{1'b0}}};
  assign word_narrow = {{LEAD_Z{1'b0}}, word_i[NARROW_W-1:0], {TAIL_NARROW{1'b0}}};

  always_comb begin
    shreg_d = shreg_q;
    oe_d    = oe_q;
    if (load_i) begin
      oe_d = 1'b1;
      if (zero_fill_i)   shreg_d = '0;
      else if (narrow_i) shreg_d = word_narrow;
      else               shreg_d = word_wide;
    end else begin
      if (shift_i)   shreg_d = {shreg_q[FRAME_LEN-2:0], 1'b0};
      if (release_i) oe_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      oe_q    <= oe_d;
    end
  end

  assign oe_o  = oe_q;
  assign sdo_o = oe_q & shreg_q[FRAME_LEN-1];

endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl #(
  parameter int FRAME_LEN   = 16,
  parameter int SMP_W       = 10,
  parameter int NARROW_W    = 8,
  parameter int LEAD_Z      = 4,
  parameter int PD_LO       = 2,
  parameter int PD_HI       = 10,
  parameter int WAKE_EDGES  = 10,
  parameter int WAKE_CYCLES = 100,
  localparam int CNT_W      = $clog2(FRAME_LEN + 1),
  localparam int WAKE_W     = $clog2(WAKE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             sclk_rise_i,
  input  logic             narrow_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             narrow_o,
  output logic             zero_fill_o,
  output logic             shift_o,
  output logic             release_o,
  output logic             converting_o,
  output logic             acquiring_o,
  output logic             powered_down_o,
  output logic             data_valid_o
);

  import adc_emu_pkg::*;

  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(LEAD_Z + SMP_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(LEAD_Z + NARROW_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL    = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_EDGE16  = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WAKE_W-1:0] wake_q, wake_d;
  res_e              res_q, res_d;
  logic              conv_q, conv_d;
  logic              acq_q, acq_d;
  logic              live_q, live_d;
  logic              pd_q, pd_d;
  logic              valid_q, valid_d;
  logic [CNT_W-1:0]  conv_last;
  logic              edge_ok;

  assign conv_last = (res_q == RES_NARROW) ? LAST_NARROW : LAST_WIDE;
  assign edge_ok   = sclk_fall_i && !cs_fall_i && !cs_rise_i && (cnt_q < CNT_FULL);

  always_comb begin
    cnt_d   = cnt_q;
    wake_d  = wake_q;
    res_d   = res_q;
    conv_d  = conv_q;
    acq_d   = acq_q;
    live_d  = live_q;
    pd_d    = pd_q;
    valid_d = valid_q;

    if (wake_q != '0) begin
      wake_d = wake_q - 1'b1;
      if (wake_q == WAKE_W'(1)) begin
        pd_d  = 1'b0;
        acq_d = 1'b1;
      end
    end

    if (cs_fall_i) begin
      cnt_d   = '0;
      res_d   = narrow_i ? RES_NARROW : RES_WIDE;
      live_d  = !pd_q;
      conv_d  = !pd_q;
      valid_d = !pd_q && acq_q;
      acq_d   = 1'b0;
    end else if (cs_rise_i) begin
      conv_d = 1'b0;
      if (live_q && !pd_q && cnt_q >= CNT_W'(PD_LO) && cnt_q < CNT_W'(PD_HI))
        pd_d = 1'b1;
    end else begin
      if (edge_ok) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == conv_last) conv_d = 1'b0;
        if (pd_q && wake_q == '0 && cnt_q == CNT_W'(WAKE_EDGES))
          wake_d = WAKE_W'(WAKE_CYCLES);
      end
      if (sclk_rise_i && live_q && cnt_q >= conv_last) acq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_FULL;
      wake_q  <= '0;
      res_q   <= RES_WIDE;
      conv_q  <= 1'b0;
      acq_q   <= 1'b1;
      live_q  <= 1'b0;
      pd_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      wake_q  <= wake_d;
      res_q   <= res_d;
      conv_q  <= conv_d;
      acq_q   <= acq_d;
      live_q  <= live_d;
      pd_q    <= pd_d;
      valid_q <= valid_d;
    end
  end

  assign cnt_o          = cnt_q;
  assign narrow_o       = narrow_i;
  assign zero_fill_o    = pd_q || !acq_q;
  assign shift_o        = edge_ok;
  assign release_o      = cs_rise_i || (edge_ok && cnt_q == CNT_EDGE16);
  assign converting_o   = conv_q;
  assign acquiring_o    = acq_q;
  assign powered_down_o = pd_q;
  assign data_valid_o   = valid_q;

endmodule

// File: rtl/adc_frame_emu.sv
module adc_frame_emu #(
  parameter int SMP_W       = 10,
  parameter int NARROW_W    = 8,
  parameter int FRAME_LEN   = 16,
  parameter int LEAD_Z      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [SMP_W-1:0] sample_in,
  input  logic             res_8bit,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             converting,
  output logic             acquiring,
  output logic             powered_down,
  output logic             data_valid
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  adc_emu_pkg::pin_edge_t cs_edge, sclk_edge;
  logic             cs_lvl, sclk_lvl;
  logic             cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic [CNT_W-1:0] edge_cnt;
  logic             narrow, zero_fill, shift, release_oe;

  adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cs_n), .level_o(cs_lvl), .edge_o(cs_edge)
  );

  adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(sclk), .level_o(sclk_lvl), .edge_o(sclk_edge)
  );

  assign cs_fall   = cs_edge.fall;
  assign cs_rise   = cs_edge.rise;
  assign sclk_fall = sclk_edge.fall & ~cs_lvl;
  assign sclk_rise = sclk_edge.rise & ~cs_lvl & sclk_lvl;

  adc_phase_ctrl #(
    .FRAME_LEN(FRAME_LEN), .SMP_W(SMP_W), .NARROW_W(NARROW_W), .LEAD_Z(LEAD_Z),
    .PD_LO(2), .PD_HI(10), .WAKE_EDGES(10), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .narrow_i(res_8bit),
    .cnt_o(edge_cnt), .narrow_o(narrow), .zero_fill_o(zero_fill),
    .shift_o(shift), .release_o(release_oe),
    .converting_o(converting), .acquiring_o(acquiring),
    .powered_down_o(powered_down), .data_valid_o(data_valid)
  );

  adc_frame_shift #(
    .FRAME_LEN(FRAME_LEN), .SMP_W(SMP_W), .NARROW_W(NARROW_W), .LEAD_Z(LEAD_Z)
  ) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(cs_fall), .narrow_i(narrow), .zero_fill_i(zero_fill),
    .word_i(sample_in), .shift_i(shift), .release_i(release_oe),
    .sdo_o(sdo), .oe_o(sdo_oe)
  );

endmodule

// File: rtl/adc_frame_emu_chk.sv
module adc_frame_emu_chk #(
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic [CNT_W-1:0] edge_cnt,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             converting,
  input logic             powered_down,
  input logic             data_valid
);

  AST_QUIET_SDO: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo); // R12

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe && edge_cnt == '0)); // R1

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= CNT_W'(FRAME_LEN)); // R4

  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> edge_cnt < CNT_W'(FRAME_LEN)); // R4

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!sdo_oe && !converting)); // R7

  AST_PD_NO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |-> !converting); // R9

  AST_PD_FRAME_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && powered_down) |=> !data_valid); // R9

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(data_valid)); // R11

endmodule

bind adc_frame_emu adc_frame_emu_chk #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .edge_cnt(edge_cnt), .sdo(sdo), .sdo_oe(sdo_oe), .converting(converting),
  .powered_down(powered_down), .data_valid(data_valid)
);

// File: tb/adc_frame_emu_bench.sv
module adc_frame_emu_bench;

  localparam int SMP_W = 10;
  localparam int WAKE  = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, sclk, res_8bit;
  logic [SMP_W-1:0] sample_in;
  logic sdo, sdo_oe, converting, acquiring, powered_down, data_valid;

  always #4 clk = ~clk;

  adc_frame_emu #(.WAKE_CYCLES(WAKE)) u_adc_frame_emu (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample_in(sample_in), .res_8bit(res_8bit),
    .sdo(sdo), .sdo_oe(sdo_oe), .converting(converting),
    .acquiring(acquiring), .powered_down(powered_down), .data_valid(data_valid)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  m_pd = 0;
  bit  m_acq = 1;
  bit  wake_pending = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_bit(logic [SMP_W-1:0] s, bit nar, bit valid, int k);
    int w;
    w = nar ? 8 : 10;
    if (!valid || k < 4 || k >= 4 + w) return 0;
    return int'(s[w - 1 - (k - 4)]);
  endfunction

  task automatic run_frame(logic [SMP_W-1:0] s, bit nar, int n, bit no_wait);
    bit    live, valid;
    int    conv_end;
    string lab;
    live     = !m_pd;
    valid    = live && m_acq;
    conv_end = nar ? 12 : 14;
    lab      = !live ? "R9" : (!m_acq ? "R11" : (nar ? "R3" : "R2"));
    sample_in = s;
    res_8bit  = nar;
    hold(1);
    cs_n = 1'b0;
    hold(4);
    chk("R1", "oe after cs fall", sdo_oe, 1);
    chk("R1", "prefix zero", sdo, 0);
    chk(valid ? "R1" : lab, "data_valid", data_valid, valid);
    chk(live ? "R5" : "R9", "converting at start", converting, live);
    for (int e = 1; e <= n; e++) begin
      sclk = 1'b0;
      hold(4);
      if (e < 16) begin
        chk(lab, "sdo slot", sdo, exp_bit(s, nar, valid, e));
        chk("R4", "oe before edge 16", sdo_oe, 1);
      end else begin
        chk("R4", "oe from edge 16", sdo_oe, 0);
        chk("R12", "sdo released", sdo, 0);
      end
      if (live && e == conv_end - 1) chk("R5", "converting before end", converting, 1);
      if (e == conv_end) chk("R5", "converting at end", converting, 0);
      sclk = 1'b1;
      hold(4);
      if (live) chk("R6", "acquiring", acquiring, (e >= conv_end - 1) ? 1 : 0);
    end
    cs_n = 1'b1;
    hold(4);
    chk("R7", "oe after cs rise", sdo_oe, 0);
    chk("R7", "converting after cs rise", converting, 0);
    if (live) begin
      m_acq = (n >= conv_end - 1);
      if (n >= 2 && n <= 9) m_pd = 1;
      chk("R8", "powered_down", powered_down, m_pd);
    end else begin
      chk("R10", "still powered down", powered_down, 1);
      if (n >= 11 || wake_pending) begin
        if (no_wait) begin
          wake_pending = 1;
        end else begin
          hold(WAKE + 10);
          m_pd = 0;
          m_acq = 1;
          wake_pending = 0;
          chk("R10", "awake after delay", powered_down, 0);
          chk("R10", "acquiring after wake", acquiring, 1);
        end
      end
    end
    hold(2);
  endtask

  initial begin
    hold(150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0;
    cs_n = 1'b1;
    sclk = 1'b1;
    res_8bit = 1'b0;
    sample_in = '0;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    chk("R12", "reset oe", sdo_oe, 0);
    chk("R12", "reset sdo", sdo, 0);
    chk("R12", "reset converting", converting, 0);
    chk("R12", "reset powered_down", powered_down, 0);
    chk("R12", "reset acquiring", acquiring, 1);
    chk("R12", "reset data_valid", data_valid, 0);

    run_frame(10'h2AA, 0, 16, 0);   // R2 full frame
    run_frame(10'h0A5, 1, 16, 0);   // R3 narrow frame
    run_frame(10'h3FF, 0, 18, 0);   // R4 extra edges
    run_frame(10'h155, 0, 12, 0);   // R11 abort before acquisition
    run_frame(10'h1C3, 0, 16, 0);   // R11 invalid frame, reaches acquisition
    run_frame(10'h2F0, 1, 16, 0);   // valid again
    run_frame(10'h111, 0, 1, 0);    // below window: no power-down
    run_frame(10'h222, 0, 14, 0);
    run_frame(10'h0F0, 1, 10, 0);   // edge 10: no power-down
    run_frame(10'h333, 0, 16, 0);
    run_frame(10'h3A5, 0, 5, 0);    // R8 enter power-down
    run_frame(10'h3FF, 0, 16, 0);   // R9 zeros while down, wakes (R10)
    run_frame(10'h2C7, 0, 16, 0);   // valid after wake
    run_frame(10'h0AA, 1, 9, 0);    // R8 upper window edge
    run_frame(10'h3FF, 1, 10, 0);   // R10 too short to wake
    run_frame(10'h3FF, 0, 11, 1);   // R10 dummy, next frame during wake
    run_frame(10'h3FF, 0, 16, 0);   // R9 frame inside wake interval
    run_frame(10'h1E1, 0, 16, 0);

    for (int i = 0; i < 40; i++) begin
      run_frame(SMP_W'($urandom), 1'($urandom), int'($urandom_range(1, 18)), 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule